// File: doc/BRIEF.md
# Serial Memory Status and Command Front End

This block is the serial-bus front end of a small nonvolatile memory. Working in mode 0 and oversampled by the chip clock, it gathers an 8-bit opcode from the serial data input while chip select is low. It then either streams the status byte back or changes the write-enable latch and the two block-protect bits. The memory array, its write timer and the address-based protection check sit elsewhere. The write timer drives the `busy` input, which appears in the status byte as the write-in-progress flag. The protect field leaves the block on `bp` for use by the array logic.

The serial inputs are sampled on the chip clock. A rising or falling edge of `sck` is seen one clock after it happens and takes effect on the next clock. Read data goes out after falling edges of `sck`, so the host can sample it on the following rising edge. Chip select going high resets the bit and byte counters.

Top module: `spi_status_regs`

## Requirements
- R1: After reset, `bp` is 2'b00 (parameter BP_INIT), the latch is clear, and a status read returns 8'h00 while `busy` is low.
- R2: The opcode 8'h05, sent MSB first, starts a status read. From the falling edge after the 8th clock, the byte {4'b0000, bp[1], bp[0], latch, busy} is shifted out MSB first, one bit per falling edge. Extra clocks repeat the byte.
- R3: `so_oe` is low while chip select is high and during the 8 opcode clocks. It goes high only after an `sck` falling edge of a status read.
- R4: Bit 0 of the status byte follows `busy`, and a status read is answered in full while `busy` is high.
- R5: Opcode 8'h06 sets the latch and 8'h04 clears it on the 8th rising edge, whatever the value of `bp`.
- R6: Opcode 8'h01 followed by one data byte sets `bp` to data bits [3:2] and clears the latch. This happens when chip select rises after exactly 16 clocks with the latch set. The other data bits have no effect.
- R7: A status write sent with the latch clear, or ended after any count of clocks other than 16, leaves `bp` and the latch unchanged.
- R8: While `busy` is high, every opcode except the status read is ignored.
- R9: `bp` changes only as described in R6. Other opcodes and unknown opcodes leave `bp` and the latch as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Chip clock used to oversample the serial inputs |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in, MSB first |
| busy | input | 1 | High while the write timer runs a cycle |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for the serial data out pad |
| bp | output | 2 | Block-protect field |

## Verification
The assertions assume that `sck`, `cs_n` and `si` change synchronously with `clk`. They also assume that each `sck` level lasts at least two clocks, so that every edge is seen as a single rise or fall. The stimulus changes inputs only on the falling edge of `clk` and holds each `sck` level for four clocks. It also holds `busy` steady for the whole of a chip-select frame, so that the decision taken at the 8th clock or at the chip-select rise sees the same value the model uses.

// File: rtl/spi_status_regs.sv
module spi_status_regs #(
  parameter logic [1:0] BP_INIT = 2'b00,
  parameter logic [7:0] OP_READ = 8'h05,
  parameter logic [7:0] OP_WEN  = 8'h06,
  parameter logic [7:0] OP_WDIS = 8'h04,
  parameter logic [7:0] OP_WRST = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sck,
  input  logic       cs_n,
  input  logic       si,
  input  logic       busy,
  output logic       so,
  output logic       so_oe,
  output logic [1:0] bp
);

  typedef enum logic [1:0] {C_NONE, C_READ, C_WRST} cmd_t;

  logic       sck_q, cs_q;
  logic [2:0] bitpos;
  logic [1:0] bytes;
  logic [7:0] sh;
  cmd_t       cmd;
  logic       wel;
  logic       so_bit, so_en;

  wire        sck_rise = sck & ~sck_q & ~cs_n;
  wire        sck_fall = ~sck & sck_q & ~cs_n;
  wire        cs_rise  = cs_n & ~cs_q;
  wire        op_done  = sck_rise && bytes == 2'd0 && bitpos == 3'd7;
  wire [7:0]  op       = {sh[6:0], si};
  wire [7:0]  stat     = {4'b0000, bp, wel, busy};
  wire        wr_ok    = cs_rise && cmd == C_WRST && bytes == 2'd2 &&
                         bitpos == 3'd0 && wel && !busy;

  assign so    = so_bit;
  assign so_oe = so_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitpos <= '0;
      bytes  <= '0;
      sh     <= '0;
      cmd    <= C_NONE;
    end else if (cs_n) begin
      bitpos <= '0;
      bytes  <= '0;
      cmd    <= C_NONE;
    end else if (sck_rise) begin
      sh     <= op;
      bitpos <= bitpos + 3'd1;
      if (bitpos == 3'd7 && bytes != 2'd3) bytes <= bytes + 2'd1;
      if (op_done) begin
        if (op == OP_READ)      cmd <= C_READ;
        else if (op == OP_WRST) cmd <= C_WRST;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
      bp  <= BP_INIT;
    end else if (wr_ok) begin
      bp  <= sh[3:2];
      wel <= 1'b0;
    end else if (op_done && !busy && !cs_n) begin
      if (op == OP_WEN)       wel <= 1'b1;
      else if (op == OP_WDIS) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_bit <= 1'b0;
      so_en  <= 1'b0;
    end else if (cs_n) begin
      so_en  <= 1'b0;
    end else if (sck_fall && cmd == C_READ) begin
      so_bit <= stat[3'd7 - bitpos];
      so_en  <= 1'b1;
    end
  end

endmodule

module spi_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       cs_n,
  input logic       busy,
  input logic       so_oe,
  input logic       wel,
  input logic [1:0] bp
);

  // R3
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> !so_oe);

  // R3
  oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(so_oe) |-> ($past(!sck) && $past(sck, 2)));

  // R9
  bp_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp != $past(bp)) |-> ($past(cs_n) && !$past(cs_n, 2)));

  // R8
  bp_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(bp));

  // R8
  wel_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(wel));

  // R6
  bp_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp != $past(bp)) |-> !wel);

endmodule

bind spi_status_regs spi_status_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .busy(busy),
  .so_oe(so_oe), .wel(wel), .bp(bp)
);

// File: tb/spi_status_regs_tb.sv
module spi_status_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, busy = 1'b0;
  logic so, so_oe;
  logic [1:0] bp;
  int n_chk = 0, n_fail = 0;
  logic [1:0] m_bp = 2'b00;
  logic m_wel = 1'b0;
  logic [31:0] rx;
  logic oe_bad;

  always #4 clk = ~clk;

  spi_status_regs dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
    .si(si), .busy(busy), .so(so), .so_oe(so_oe), .bp(bp));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] tx, input int nbits);
    rx = '0;
    oe_bad = 1'b0;
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      si = tx[31 - i];
      wait_clk(4);
      rx[31 - i] = so;
      if (i < 8 && so_oe) oe_bad = 1'b1;
      if (i >= 8 && !so_oe && tx[31:24] == 8'h05) oe_bad = 1'b1;
      sck = 1'b1;
      wait_clk(4);
      sck = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(4);
    if (so_oe) oe_bad = 1'b1;
  endtask

  function automatic logic [7:0] stat_of(input logic [1:0] b, input logic w, input logic bz);
    return {4'b0000, b, w, bz};
  endfunction

  task automatic model(input logic [7:0] op, input logic [7:0] d, input int nbits);
    if (busy || nbits < 8) return;
    if (op == 8'h06) m_wel = 1'b1;
    else if (op == 8'h04) m_wel = 1'b0;
    else if (op == 8'h01 && nbits == 16 && m_wel) begin
      m_bp = d[3:2];
      m_wel = 1'b0;
    end
  endtask

  task automatic rd_check(input string req);
    frame({8'h05, 24'h0}, 16);
    chk(req, {24'h0, rx[23:16]}, {24'h0, stat_of(m_bp, m_wel, busy)});
    chk({req, " oe"}, {31'h0, oe_bad}, 32'h0);
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] d, input int nbits, input string req);
    frame({op, d, 16'h0}, nbits);
    model(op, d, nbits);
    chk({req, " bp"}, {30'h0, bp}, {30'h0, m_bp});
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R1 reset state
    chk("R1 bp", {30'h0, bp}, 32'h0);
    chk("R3 idle oe", {31'h0, so_oe}, 32'h0);
    rd_check("R1 status");
    // R5 latch set and clear
    cmd(8'h06, 8'h00, 8, "R5");
    rd_check("R5 wel set");
    cmd(8'h04, 8'h00, 8, "R5");
    rd_check("R5 wel clear");
    // R7 write with latch clear
    cmd(8'h01, 8'h0C, 16, "R7 no wel");
    // R6 write with latch set, other bits ignored
    cmd(8'h06, 8'h00, 8, "R5");
    cmd(8'h01, 8'hF3 | 8'h0C, 16, "R6");
    chk("R6 bp value", {30'h0, bp}, 32'h3);
    rd_check("R6 wel cleared");
    // R5 latch works with full protection
    cmd(8'h06, 8'h00, 8, "R5 protected");
    rd_check("R5 wel under bp=11");
    // R7 wrong clock counts
    cmd(8'h01, 8'h04, 17, "R7 17 clocks");
    cmd(8'h01, 8'h04, 15, "R7 15 clocks");
    rd_check("R7 wel kept");
    // R9 unknown opcode
    cmd(8'hA5, 8'h00, 8, "R9 junk");
    rd_check("R9 after junk");
    // R2 repeat on extra clocks
    frame({8'h05, 24'h0}, 32);
    chk("R2 repeat", {8'h0, rx[23:0]}, {8'h0, {3{stat_of(m_bp, m_wel, 1'b0)}}});
    // R4 and R8 while busy
    busy = 1'b1;
    wait_clk(2);
    rd_check("R4 busy read");
    cmd(8'h04, 8'h00, 8, "R8 wdis busy");
    cmd(8'h01, 8'h00, 16, "R8 wrsr busy");
    rd_check("R8 state kept");
    busy = 1'b0;
    wait_clk(2);
    // random mix
    for (int k = 0; k < 120; k++) begin
      logic [7:0] op, d;
      int sel, nb;
      sel = $urandom_range(0, 5);
      busy = ($urandom_range(0, 3) == 0);
      wait_clk(2);
      d = 8'($urandom);
      nb = 8;
      case (sel)
        0: op = 8'h06;
        1: op = 8'h04;
        2: begin op = 8'h01; nb = 16; end
        3: begin op = 8'h01; nb = 15 + $urandom_range(0, 2); end
        4: op = 8'($urandom) | 8'h80;
        default: op = 8'h05;
      endcase
      if (op == 8'h05) rd_check("R2 random read");
      else cmd(op, d, nb, "R9 random");
    end
    busy = 1'b0;
    wait_clk(2);
    rd_check("R2 final");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_200_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule